// File: doc/BRIEF.md
# Concatenated Decode Flow Controller

This block sequences the decoding of one stored codeword protected by two code layers: several identical outer hard-decision block codes, each guarding its own disjoint group of information bits, and one inner iterative soft-decision code that covers the whole readout. The controller does not decode anything itself. It starts the outer decoders and the inner decoder through pulse handshakes, collects one success flag per outer group, and decides what runs next.

After a new codeword is requested, the outer decoders first work directly on the raw systematic bits. If every group succeeds, the job ends without the inner decoder. Otherwise the inner decoder runs, the outer decoders run again on its hard output, and the controller keeps looping. Each loop grows a per-bit trusted mask, in inner-codeword bit order, that the inner decoder uses to pin already-verified bits on its next pass. The loop ends when every group succeeds, when the number of successful groups does not grow, or when a maximum loop count is reached. A final status reports overall success, the loop count and a map of failed groups.

Top module: `concat_dec_ctrl`

## Requirements
- R1: A `start` pulse while idle raises `busy` and produces a one-cycle `outer_start` with `outer_src` = 0 (raw readout) on the next clock edge.
- R2: If every bit of `outer_ok` is 1 on the first outer pass, the job ends with `all_ok` = 1, `iter_cnt` = 0, and `inner_start` is never pulsed.
- R3: If the first outer pass has any failing group, `inner_start` pulses once; each `inner_done` then produces an `outer_start` with `outer_src` = 1 (inner hard output).
- R4: Group g owns mask positions g*GRP_LEN to g*GRP_LEN+GRP_LEN-1. After each outer pass that follows an inner pass, the positions of every group with its `outer_ok` bit set are ORed into `trust_mask`; bits are never cleared during a job.
- R5: Positions NUM_GRP*GRP_LEN to SYS_LEN-1 are zero padding with a known value and are set in `trust_mask` at the first mask update of a job.
- R6: After an outer pass that follows an inner pass, the job ends if the count of successful groups equals the count of the previous outer pass.
- R7: The job ends once `iter_cnt` (completed inner passes) reaches MAX_OUTER; `iter_cnt` never exceeds MAX_OUTER.
- R8: At job end `done` pulses for one cycle as `busy` falls; `all_ok` is 1 only if all groups succeeded on the last pass, bit g of `fail_map` is 1 when group g failed on the last pass, and these values hold until the next job starts.
- R9: `trust_mask` is all zero from the first cycle of a new job until its first update.
- R10: A `start` pulse while `busy` is high has no effect: no extra outer pass is started.
- R11: `outer_start` and `inner_start` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request decoding of a new codeword |
| outer_start | output | 1 | One-cycle pulse starting all outer decoders |
| outer_src | output | 1 | 0: outer decoders read raw bits, 1: inner decoder output |
| outer_done | input | 1 | Outer decoders finished; `outer_ok` valid this cycle |
| outer_ok | input | NUM_GRP | Per-group success flags |
| inner_start | output | 1 | One-cycle pulse starting the inner decoder |
| inner_done | input | 1 | Inner decoder finished |
| trust_mask | output | SYS_LEN | Per-bit trusted mask for the inner decoder |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle job-end pulse |
| all_ok | output | 1 | All groups succeeded on the last pass |
| iter_cnt | output | $clog2(MAX_OUTER+1) | Number of inner passes used |
| fail_map | output | NUM_GRP | Groups that failed on the last pass |

## Verification
Every cycle the assertions check that the two start pulses never coincide, that the loop count stays within its limit, that the trusted mask only grows during a job, that a job begins with a raw-source outer pass, and that the end of a job carries a consistent status. Which termination rule fires, the exact mask contents, the number of inner and outer passes and the status values depend on the scripted sequence of group results, so only the bench scenarios show them: first-pass success, stalled growth with equal and with different group sets, the loop limit, and full success at the limit.

// File: rtl/concat_dec_pkg.sv
package concat_dec_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_OUTER = 2'd1,
    ST_INNER = 2'd2
  } flow_state_t;
endpackage

// File: rtl/grp_popcount.sv
module grp_popcount #(
  parameter int N  = 4,
  localparam int CW = $clog2(N + 1)
) (
  input  logic [N-1:0]  bits,
  output logic [CW-1:0] cnt
);
  always_comb begin
    cnt = '0;
    for (int i = 0; i < N; i++) begin
      cnt = cnt + CW'(bits[i]);
    end
  end
endmodule

// File: rtl/trust_expand.sv
module trust_expand #(
  parameter int NUM_GRP = 4,
  parameter int GRP_LEN = 8,
  parameter int SYS_LEN = 36,
  localparam int USED = NUM_GRP * GRP_LEN,
  localparam int PAD  = SYS_LEN - USED
) (
  input  logic [NUM_GRP-1:0] grp_ok,
  output logic [SYS_LEN-1:0] grp_bits,
  output logic [SYS_LEN-1:0] pad_bits
);
  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    assign grp_bits[g*GRP_LEN +: GRP_LEN] = {GRP_LEN{grp_ok[g]}};
    assign pad_bits[g*GRP_LEN +: GRP_LEN] = '0;
  end
  if (PAD > 0) begin : g_pad
    assign grp_bits[SYS_LEN-1:USED] = '0;
    assign pad_bits[SYS_LEN-1:USED] = '1;
  end
endmodule

// File: rtl/concat_dec_ctrl.sv
module concat_dec_ctrl
  import concat_dec_pkg::*;
#(
  parameter int NUM_GRP   = 4,
  parameter int GRP_LEN   = 8,
  parameter int SYS_LEN   = 36,
  parameter int MAX_OUTER = 2,
  localparam int IW = $clog2(MAX_OUTER + 1),
  localparam int CW = $clog2(NUM_GRP + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  output logic               outer_start,
  output logic               outer_src,
  input  logic               outer_done,
  input  logic [NUM_GRP-1:0] outer_ok,
  output logic               inner_start,
  input  logic               inner_done,
  output logic [SYS_LEN-1:0] trust_mask,
  output logic               busy,
  output logic               done,
  output logic               all_ok,
  output logic [IW-1:0]      iter_cnt,
  output logic [NUM_GRP-1:0] fail_map
);
  flow_state_t       state;
  logic [CW-1:0]     ok_cnt;
  logic [CW-1:0]     prev_cnt;
  logic [SYS_LEN-1:0] grp_bits;
  logic [SYS_LEN-1:0] pad_bits;
  logic              every_ok;
  logic              stop_loop;

  grp_popcount #(.N(NUM_GRP)) i_cnt (
    .bits (outer_ok),
    .cnt  (ok_cnt)
  );

  trust_expand #(
    .NUM_GRP (NUM_GRP),
    .GRP_LEN (GRP_LEN),
    .SYS_LEN (SYS_LEN)
  ) i_expand (
    .grp_ok   (outer_ok),
    .grp_bits (grp_bits),
    .pad_bits (pad_bits)
  );

  assign every_ok  = &outer_ok;
  assign stop_loop = every_ok || (ok_cnt == prev_cnt) || (iter_cnt >= IW'(MAX_OUTER));

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      outer_start <= 1'b0;
      outer_src   <= 1'b0;
      inner_start <= 1'b0;
      trust_mask  <= '0;
      busy        <= 1'b0;
      done        <= 1'b0;
      all_ok      <= 1'b0;
      iter_cnt    <= '0;
      fail_map    <= '0;
      prev_cnt    <= '0;
    end else begin
      outer_start <= 1'b0;
      inner_start <= 1'b0;
      done        <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            trust_mask  <= '0;
            iter_cnt    <= '0;
            all_ok      <= 1'b0;
            fail_map    <= '0;
            busy        <= 1'b1;
            outer_start <= 1'b1;
            outer_src   <= 1'b0;
            state       <= ST_OUTER;
          end
        end
        ST_OUTER: begin
          if (outer_done) begin
            if (outer_src) begin
              trust_mask <= trust_mask | grp_bits | pad_bits;
            end
            if (outer_src ? stop_loop : every_ok) begin
              all_ok   <= every_ok;
              fail_map <= ~outer_ok;
              done     <= 1'b1;
              busy     <= 1'b0;
              state    <= ST_IDLE;
            end else begin
              prev_cnt    <= ok_cnt;
              inner_start <= 1'b1;
              state       <= ST_INNER;
            end
          end
        end
        ST_INNER: begin
          if (inner_done) begin
            iter_cnt    <= iter_cnt + 1'b1;
            outer_start <= 1'b1;
            outer_src   <= 1'b1;
            state       <= ST_OUTER;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/concat_dec_ctrl_chk.sv
module concat_dec_ctrl_chk #(
  parameter int NUM_GRP   = 4,
  parameter int SYS_LEN   = 36,
  parameter int MAX_OUTER = 2,
  localparam int IW = $clog2(MAX_OUTER + 1)
) (
  input logic               clk,
  input logic               rst,
  input logic               outer_start,
  input logic               outer_src,
  input logic               inner_start,
  input logic [SYS_LEN-1:0] trust_mask,
  input logic               busy,
  input logic               done,
  input logic               all_ok,
  input logic [IW-1:0]      iter_cnt,
  input logic [NUM_GRP-1:0] fail_map
);
  assert_excl_R11: assert property (@(posedge clk) disable iff (rst)
    !(outer_start && inner_start));

  assert_iter_max_R7: assert property (@(posedge clk) disable iff (rst)
    iter_cnt <= IW'(MAX_OUTER));

  assert_mask_grow_R4: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ((trust_mask & $past(trust_mask)) == $past(trust_mask)));

  assert_raw_first_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (outer_start && !outer_src));

  assert_end_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  assert_status_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> (all_ok == (fail_map == '0)));
endmodule

bind concat_dec_ctrl concat_dec_ctrl_chk #(
  .NUM_GRP   (NUM_GRP),
  .SYS_LEN   (SYS_LEN),
  .MAX_OUTER (MAX_OUTER)
) i_chk (
  .clk         (clk),
  .rst         (rst),
  .outer_start (outer_start),
  .outer_src   (outer_src),
  .inner_start (inner_start),
  .trust_mask  (trust_mask),
  .busy        (busy),
  .done        (done),
  .all_ok      (all_ok),
  .iter_cnt    (iter_cnt),
  .fail_map    (fail_map)
);

// File: tb/test_concat_dec_ctrl.sv
module test_concat_dec_ctrl;
  localparam int NG = 4;
  localparam int GL = 8;
  localparam int SL = 36;
  localparam int MX = 2;

  typedef struct packed {
    logic [3:0] ok0;
    logic [3:0] ok1;
    logic [3:0] ok2;
    logic [1:0] iter;
    logic       allok;
    logic [3:0] fail;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{4'hF, 4'h0, 4'h0, 2'd0, 1'b1, 4'h0},
    '{4'h3, 4'hF, 4'h0, 2'd1, 1'b1, 4'h0},
    '{4'h1, 4'h1, 4'h0, 2'd1, 1'b0, 4'hE},
    '{4'h1, 4'h3, 4'h7, 2'd2, 1'b0, 4'h8},
    '{4'h0, 4'h0, 4'h0, 2'd1, 1'b0, 4'hF},
    '{4'h4, 4'h6, 4'hF, 2'd2, 1'b1, 4'h0},
    '{4'h1, 4'h2, 4'h0, 2'd1, 1'b0, 4'hD}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic outer_done = 1'b0;
  logic [NG-1:0] outer_ok = '0;
  logic inner_done = 1'b0;
  logic outer_start, outer_src, inner_start, busy, done, all_ok;
  logic [SL-1:0] trust_mask;
  logic [1:0] iter_cnt;
  logic [NG-1:0] fail_map;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  concat_dec_ctrl #(.NUM_GRP(NG), .GRP_LEN(GL), .SYS_LEN(SL), .MAX_OUTER(MX)) i_concat_dec_ctrl (
    .clk(clk), .rst(rst), .start(start),
    .outer_start(outer_start), .outer_src(outer_src),
    .outer_done(outer_done), .outer_ok(outer_ok),
    .inner_start(inner_start), .inner_done(inner_done),
    .trust_mask(trust_mask), .busy(busy), .done(done),
    .all_ok(all_ok), .iter_cnt(iter_cnt), .fail_map(fail_map)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [SL-1:0] mask_of(input logic [NG-1:0] acc, input logic pad);
    logic [SL-1:0] m = '0;
    for (int g = 0; g < NG; g++)
      for (int b = 0; b < GL; b++) m[g*GL+b] = acc[g];
    if (pad)
      for (int p = NG*GL; p < SL; p++) m[p] = 1'b1;
    return m;
  endfunction

  task automatic run_vec(input int vi);
    vec_t v = VECS[vi];
    int n_out = 0;
    int n_in = 0;
    int guard = 0;
    logic fin = 1'b0;
    logic [NG-1:0] acc;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!fin && guard < 200) begin
      guard++;
      if (outer_start) begin
        if (n_out == 0) begin
          check("R1 raw source", 64'(outer_src), 64'd0);
          check("R9 mask cleared", 64'(trust_mask), 64'd0);
        end else begin
          check("R3 inner source", 64'(outer_src), 64'd1);
        end
        n_out++;
        repeat (2) @(negedge clk);
        outer_done = 1'b1;
        outer_ok = (n_out == 1) ? v.ok0 : (n_out == 2) ? v.ok1 : v.ok2;
        @(negedge clk);
        outer_done = 1'b0;
        outer_ok = '0;
      end else if (inner_start) begin
        n_in++;
        start = 1'b1;               // R10: start during a job must be ignored
        @(negedge clk); start = 1'b0;
        repeat (2) @(negedge clk);
        inner_done = 1'b1;
        @(negedge clk); inner_done = 1'b0;
      end else if (done) begin
        fin = 1'b1;
        check("R8 busy low at done", 64'(busy), 64'd0);
      end else begin
        @(negedge clk);
      end
    end
    if (!fin) check("R8 watchdog done", 64'd0, 64'd1);
    acc = ((v.iter >= 1) ? v.ok1 : 4'h0) | ((v.iter >= 2) ? v.ok2 : 4'h0);
    check("R8 all_ok", 64'(all_ok), 64'(v.allok));
    check("R8 fail_map", 64'(fail_map), 64'(v.fail));
    check(v.iter == 2 ? "R7 iter_cnt" : "R6 iter_cnt", 64'(iter_cnt), 64'(v.iter));
    check("R4 R5 trust_mask", 64'(trust_mask), 64'(mask_of(acc, v.iter != 0)));
    check("R10 outer passes", 64'(n_out), 64'(v.iter) + 64'd1);
    check(v.iter == 0 ? "R2 no inner" : "R3 inner passes", 64'(n_in), 64'(v.iter));
    repeat (3) @(negedge clk);
    check("R8 status held", 64'({all_ok, fail_map, iter_cnt}), 64'({v.allok, v.fail, v.iter}));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset busy", 64'(busy), 64'd0);
    check("R8 reset done", 64'(done), 64'd0);
    check("R11 reset starts", 64'({outer_start, inner_start}), 64'd0);
    check("R9 reset mask", 64'(trust_mask), 64'd0);
    check("R7 reset iter", 64'(iter_cnt), 64'd0);
    for (int i = 0; i < NV; i++) run_vec(i);
    // R1: busy rises one edge after start
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check("R1 busy", 64'(busy), 64'd1);
    check("R1 outer_start", 64'(outer_start), 64'd1);
    @(negedge clk);
    check("R1 single pulse", 64'(outer_start), 64'd0);
    outer_done = 1'b1; outer_ok = 4'hF;
    @(negedge clk); outer_done = 1'b0; outer_ok = '0;
    check("R2 done pulse", 64'(done), 64'd1);
    @(negedge clk);
    check("R8 done one cycle", 64'(done), 64'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule